// File: doc/BRIEF.md
# Two-Channel DAC Data Front End

This block sits between a digital sample source and a pair of 8-bit current-steering converter cores. It holds each channel's sample in two register stages. A write strobe fills a channel input register, and an update strobe moves that register into the code register that drives the core. The whole block runs on one system clock. The write, update and control lines are sampled levels, and their rising edges are detected inside the block.

A mode input picks between two layouts. In dual layout, each channel has its own data bus, write strobe and update strobe, and the two channels run independently. In interleaved layout, a single data bus carries alternating I and Q words. Channel A's write line captures a word. Channel B's write line becomes a steering select. Channel A's update line becomes a shared update strobe. Channel B's update line becomes a hold input, which restarts an internal divide-by-two. Both code registers then load together on every second update edge, so each output runs at half the word rate.

An `upd_a`/`upd_b` pulse marks every load of a code register, which lets a reference model track the outputs.

Top module: `iq_dac_front`

## Requirements
- R1: While `rst` is high at a clock edge, both input registers, both code registers and the divider phase clear. After reset, `code_a`, `code_b`, `upd_a` and `upd_b` all read 0.
- R2: In dual layout (`dual_mode`=1), a rising edge on a channel's update line loads that channel's input register into its code register and pulses that channel's `upd` output high for exactly one cycle. The other channel's code and `upd` are unaffected, and a code register never changes without its `upd` pulse.
- R3: A rising edge on a write line loads only the input register. The code output stays unchanged until a later update edge.
- R4: When a write edge and an update edge of the same channel fall in the same cycle, the code register takes the input register's previous content. The new word appears on the next update edge.
- R5: Samples are straight binary. Bit 7 of the data bus is the MSB, and the word reaches the code output unchanged.
- R6: In interleaved layout (`dual_mode`=0), a rising edge of `a_wr` captures `a_data`. It goes into channel A's input register when `b_wr` (select) is 1, and into channel B's input register when `b_wr` is 0.
- R7: In interleaved layout, while `b_clk` (hold) is 1, edges on `a_clk` change neither code register and produce no `upd` pulse.
- R8: In interleaved layout, the first rising edge of `a_clk` after the hold goes low loads both code registers at once, with `upd_a` and `upd_b` pulsing together.
- R9: After that first load, the code registers load only on every second rising edge of `a_clk`, so N update edges give N/2 loads.
- R10: In interleaved layout, `b_data` and rising edges of `b_wr` write nothing into either input register.
- R11: Raising and lowering the hold again restarts the divider, so the next update edge loads both channels whatever the phase was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = two independent ports, 0 = interleaved port |
| a_data | input | W | Channel A data; shared I/Q bus when interleaved |
| a_wr | input | 1 | Channel A write; I/Q write when interleaved |
| a_clk | input | 1 | Channel A update; shared update when interleaved |
| b_data | input | W | Channel B data; unused when interleaved |
| b_wr | input | 1 | Channel B write; steering select when interleaved |
| b_clk | input | 1 | Channel B update; divider hold when interleaved |
| code_a | output | W | Code driving converter core A |
| code_b | output | W | Code driving converter core B |
| upd_a | output | 1 | One-cycle pulse when `code_a` loads |
| upd_b | output | 1 | One-cycle pulse when `code_b` loads |

## Verification
The bench builds the block with its default width W=8. At this width, the all-ones code 0xFF and the lone-MSB code 0x80 can be checked bit-exactly against straight binary. The strobes are driven for one system cycle at a time. This places write and update edges in the same cycle for the ordering case, and holds the interleaved phase at a known point before the hold input is pulsed. It also allows long update-edge runs for counting the half-rate loads.

// File: rtl/iq_dac_front.sv
module iq_dac_front #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dual_mode,
  input  logic [W-1:0] a_data,
  input  logic         a_wr,
  input  logic         a_clk,
  input  logic [W-1:0] b_data,
  input  logic         b_wr,
  input  logic         b_clk,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic         upd_a,
  output logic         upd_b
);

  logic a_wr_q, a_clk_q, b_wr_q, b_clk_q;
  logic [W-1:0] hold_a, hold_b;
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_wr_q  <= 1'b0;
      a_clk_q <= 1'b0;
      b_wr_q  <= 1'b0;
      b_clk_q <= 1'b0;
    end else begin
      a_wr_q  <= a_wr;
      a_clk_q <= a_clk;
      b_wr_q  <= b_wr;
      b_clk_q <= b_clk;
    end
  end

  wire a_wr_rise  = a_wr  & ~a_wr_q;
  wire a_clk_rise = a_clk & ~a_clk_q;
  wire b_wr_rise  = b_wr  & ~b_wr_q;
  wire b_clk_rise = b_clk & ~b_clk_q;

  wire iq_sel  = b_wr;
  wire iq_hold = b_clk;

  wire         ld_a  = dual_mode ? a_wr_rise : (a_wr_rise &  iq_sel);
  wire         ld_b  = dual_mode ? b_wr_rise : (a_wr_rise & ~iq_sel);
  wire [W-1:0] src_b = dual_mode ? b_data : a_data;

  wire iq_tick = ~dual_mode & ~iq_hold & a_clk_rise & ~phase;
  wire go_a    = dual_mode ? a_clk_rise : iq_tick;
  wire go_b    = dual_mode ? b_clk_rise : iq_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
      code_a <= '0;
      code_b <= '0;
      upd_a  <= 1'b0;
      upd_b  <= 1'b0;
      phase  <= 1'b0;
    end else begin
      if (ld_a) hold_a <= a_data;
      if (ld_b) hold_b <= src_b;
      if (go_a) code_a <= hold_a;
      if (go_b) code_b <= hold_b;
      upd_a <= go_a;
      upd_b <= go_b;
      if (dual_mode || iq_hold) phase <= 1'b0;
      else if (a_clk_rise)      phase <= ~phase;
    end
  end

  a_r1_cleared: assert property (@(posedge clk)
    $past(rst) && !rst |-> code_a == '0 && code_b == '0 && !upd_a && !upd_b);

  a_r2_code_holds: assert property (@(posedge clk) disable iff (rst)
    !upd_a && !$past(rst) |-> $stable(code_a));

  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    !dual_mode && b_clk |=> !upd_a && !upd_b);

  a_r8_paired: assert property (@(posedge clk) disable iff (rst)
    !dual_mode && !$past(dual_mode) && !$past(rst) |-> upd_a == upd_b);

endmodule

// File: tb/sim_iq_dac_front.sv
module sim_iq_dac_front;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, dual_mode = 1'b1;
  logic [7:0] a_data = '0, b_data = '0;
  logic a_wr = 1'b0, a_clk = 1'b0, b_wr = 1'b0, b_clk = 1'b0;
  logic [7:0] code_a, code_b;
  logic upd_a, upd_b;

  int n_run = 0, n_fail = 0;
  logic s_ua, s_ub;
  logic [7:0] s_ca, s_cb;

  iq_dac_front #(.W(8)) u0 (
    .clk(clk), .rst(rst), .dual_mode(dual_mode),
    .a_data(a_data), .a_wr(a_wr), .a_clk(a_clk),
    .b_data(b_data), .b_wr(b_wr), .b_clk(b_clk),
    .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input int w, input logic v);
    case (w)
      0: a_wr = v;
      1: a_clk = v;
      2: b_wr = v;
      default: b_clk = v;
    endcase
  endtask

  task automatic pulse(input int w);
    drive(w, 1'b1);
    step();
    s_ua = upd_a; s_ub = upd_b; s_ca = code_a; s_cb = code_b;
    drive(w, 1'b0);
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    rst = 1'b0; step();
    chk("R1 code_a", code_a, 8'h00);
    chk("R1 code_b", code_b, 8'h00);
    chk("R1 upd", {upd_a, upd_b}, 2'b00);
  endtask

  task automatic t_dual();
    dual_mode = 1'b1; a_data = 8'h5A;
    pulse(0);
    chk("R3 code_a after write only", code_a, 8'h00);
    pulse(1);
    chk("R2 code_a loaded", s_ca, 8'h5A);
    chk("R2 upd_a pulse", s_ua, 1'b1);
    chk("R2 upd_b quiet", s_ub, 1'b0);
    chk("R2 code_b untouched", s_cb, 8'h00);
    chk("R2 upd_a one cycle", upd_a, 1'b0);
    b_data = 8'hC3;
    pulse(2);
    chk("R3 code_b after write only", code_b, 8'h00);
    pulse(3);
    chk("R2 code_b loaded", s_cb, 8'hC3);
    chk("R2 code_a kept", s_ca, 8'h5A);
    chk("R2 upd_a quiet on B", s_ua, 1'b0);
  endtask

  task automatic t_same_edge();
    a_data = 8'h11; a_wr = 1'b1; a_clk = 1'b1;
    step();
    chk("R4 old word on same edge", code_a, 8'h5A);
    a_wr = 1'b0; a_clk = 1'b0;
    step();
    pulse(1);
    chk("R4 new word next edge", s_ca, 8'h11);
  endtask

  task automatic t_binary();
    a_data = 8'hFF; pulse(0); pulse(1);
    chk("R5 all ones", code_a, 8'hFF);
    a_data = 8'h80; pulse(0); pulse(1);
    chk("R5 msb only", code_a, 8'h80);
  endtask

  task automatic t_interleave();
    dual_mode = 1'b0; b_clk = 1'b1; step();
    b_wr = 1'b1; a_data = 8'h20; pulse(0);
    b_wr = 1'b0; a_data = 8'h40; b_data = 8'hEE; pulse(0);
    pulse(1);
    chk("R7 no load during hold", s_ua | s_ub, 1'b0);
    chk("R7 code_a held", s_ca, 8'h80);
    b_clk = 1'b0; step();
    pulse(1);
    chk("R6 select high to A", s_ca, 8'h20);
    chk("R6 select low to B", s_cb, 8'h40);
    chk("R8 both upd", {s_ua, s_ub}, 2'b11);
    b_wr = 1'b1; a_data = 8'h21; pulse(0);
    b_wr = 1'b0; a_data = 8'h41; pulse(0);
    pulse(1);
    chk("R9 skip second edge", {s_ua, s_ub}, 2'b00);
    chk("R9 code_a unchanged", s_ca, 8'h20);
    pulse(1);
    chk("R9 third edge loads A", s_ca, 8'h21);
    chk("R9 third edge loads B", s_cb, 8'h41);
    b_data = 8'hEE;
    pulse(2);
    pulse(1); pulse(1);
    chk("R10 b bus ignored", s_cb, 8'h41);
    chk("R10 a kept", s_ca, 8'h21);
  endtask

  task automatic t_rate();
    int loads = 0;
    for (int i = 0; i < 8; i++) begin
      pulse(1);
      if (s_ua) loads++;
    end
    chk("R9 half rate loads", loads, 4);
    b_clk = 1'b1; step();
    b_clk = 1'b0; step();
    pulse(1);
    chk("R11 resync loads", {s_ua, s_ub}, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_dual();
    t_same_edge();
    t_binary();
    t_interleave();
    t_rate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule